// File: doc/BRIEF.md
# Oversampling Serial Receiver with Centre Majority Vote

This block recovers asynchronous serial frames from one receive line. An external divider supplies a one-cycle enable, `tick_en`, at a fixed multiple of the bit rate. That multiple is 16 in normal mode and 8 when `fast_mode` is high. The line passes through a two-flop synchronizer. The receiver then counts enables inside each bit period and takes three samples around the middle of the bit. It registers the value that at least two of those samples agree on. The start bit, every data bit, the optional parity bit and the first stop bit are all resolved this way.

When a frame completes, the block presents the data on `rx_data` with a one-cycle `rx_valid` strobe. With the data it reports a parity mismatch flag and a framing flag. As soon as the stop bit has been voted, the receiver can accept the falling edge of the next start bit, without waiting for the stop bit to reach its full length. Word length (5 to 8 bits) and parity mode come from static configuration inputs. These inputs, and `fast_mode`, may only change while the line is idle.

The controller is a five-state machine:
- IDLE waits for a low sample on an enable cycle and then moves to START.
- START returns to IDLE if the centre vote is high, which rejects a glitch. Otherwise it moves to DATA at the end of the bit period.
- DATA collects the configured number of bits, least significant first. It then moves to PARITY if parity is enabled, or to STOP if it is not.
- PARITY records one voted bit and moves to STOP at the end of the bit period.
- STOP publishes the result and returns to IDLE on the enable cycle of its last vote sample.

Top module: `serial_vote_rx`

## Requirements
- R1: State only advances on cycles where `tick_en` is high. A bit lasts 16 enables when `fast_mode`=0 and 8 enables when `fast_mode`=1. Frames are decoded correctly in both modes.
- R2: Each bit is the majority of the samples in slots 8, 9 and 10 of the bit (normal mode) or slots 4, 5 and 6 (fast mode). A single disagreeing sample among the three does not change the bit. Two disagreeing samples flip the bit.
- R3: A falling edge starts a frame only if the start bit's centre vote is 0. A low pulse that has ended before the centre samples produces no `rx_valid`, and an idle-high line never produces `rx_valid`.
- R4: `data_len` gives the word length: 0 → 5 bits, 1 → 6, 2 → 7, 3 → 8. Data is received least significant bit first, and bits of `rx_data` above the word length read 0.
- R5: `par_mode` encoding: 0 or 3 means no parity bit, 1 means even, 2 means odd. `rx_par_err` is 1 when the received data plus the parity bit do not have the selected parity. It is always 0 when there is no parity bit.
- R6: If the voted first stop bit is 0, `rx_frm_err` is 1 for that frame, and the data is still delivered with `rx_valid`.
- R7: Only the first stop bit is checked. Further stop bits, or any length of idle line, do not affect the result.
- R8: A new start bit may begin right after the last vote sample of the stop bit. That is slot 11 of the stop bit in normal mode and slot 7 in fast mode. It is received correctly.
- R9: `rx_valid` is high for exactly one clock per frame. `rx_data`, `rx_par_err` and `rx_frm_err` hold their values until the next `rx_valid`.
- R10: After reset, `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Oversampling enable, one clock per sample slot |
| fast_mode | input | 1 | 0: 16 slots per bit, 1: 8 slots per bit |
| data_len | input | 2 | Word length select, 5 + value bits |
| par_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | DATA_MAX | Received word, upper unused bits 0 |
| rx_valid | output | 1 | One-cycle frame-complete strobe |
| rx_par_err | output | 1 | Parity mismatch for the presented frame |
| rx_frm_err | output | 1 | First stop bit voted low for the presented frame |

## Verification
The bench injects one or two inverted samples into the centre of a data bit. A receiver that used a single sample would corrupt the bit in the first case, and a receiver with the wrong vote window would fail to flip it in the second. Back-to-back frames whose stop bit is cut to 11 or 7 slots catch a receiver that stays in the stop bit too long or votes the stop bit from the wrong slots, because it would then lose or misalign the next frame. A short low glitch must produce no frame, which exposes a receiver that skips start confirmation. A stop bit held low must raise the framing flag without creating a phantom frame from the trailing low level. Every word length and parity mode is swept in both speeds, and all byte values are swept in fast mode with even parity, so that slips in bit order, masking or parity polarity show up.

// File: rtl/svr_pkg.sv
package svr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_EVEN     = 2'd1,
        PAR_ODD      = 2'd2,
        PAR_NONE_ALT = 2'd3
    } par_mode_e;

    // two-of-three decision
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/svr_sync.sv
module svr_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/svr_slot_vote.sv
module svr_slot_vote
    import svr_pkg::*;
#(
    parameter int OSR_NORM = 16,
    parameter int OSR_FAST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fast,
    input  logic run,
    input  logic clr,
    input  logic smp,
    output logic bit_end,
    output logic vote_done,
    output logic vote_val
);
    localparam int CW = $clog2(OSR_NORM + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] slot;
    logic [CW-1:0] last_slot;
    logic [CW-1:0] mid_a;
    logic [CW-1:0] mid_b;
    logic [CW-1:0] mid_c;
    logic          adv;
    logic          smp_a_q;
    logic          smp_b_q;

    always_comb begin
        last_slot = fast ? CW'(OSR_FAST) : CW'(OSR_NORM);
        mid_a     = last_slot >> 1;
        mid_b     = mid_a + CW'(1);
        mid_c     = mid_a + CW'(2);
        slot      = cnt_q + CW'(1);
        adv       = tick & run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (slot == last_slot) ? '0 : slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_a_q <= 1'b1;
            smp_b_q <= 1'b1;
        end else if (adv) begin
            if (slot == mid_a) smp_a_q <= smp;
            if (slot == mid_b) smp_b_q <= smp;
        end
    end

    always_comb begin
        bit_end   = adv && (slot == last_slot);
        vote_done = adv && (slot == mid_c);
        vote_val  = maj3(smp_a_q, smp_b_q, smp);
    end

endmodule

// File: rtl/svr_frame_fsm.sv
module svr_frame_fsm
    import svr_pkg::*;
#(
    parameter int DATA_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rxs,
    input  logic                vote_done,
    input  logic                vote_val,
    input  logic                bit_end,
    input  logic [1:0]          len_sel,
    input  logic [1:0]          par_sel,
    output logic                run,
    output logic                clr,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_par_err,
    output logic                rx_frm_err
);
    localparam int LEN_MIN = DATA_MAX - 3;
    localparam int IW      = $clog2(DATA_MAX);

    rx_state_e           state_q;
    rx_state_e           state_nx;
    logic [DATA_MAX-1:0] shf_q;
    logic [IW-1:0]       idx_q;
    logic [IW-1:0]       last_idx;
    logic                acc_q;
    logic                pbit_q;
    logic                par_on;
    logic                par_odd;
    logic                start_seen;

    always_comb begin
        par_on     = (par_mode_e'(par_sel) == PAR_EVEN) || (par_mode_e'(par_sel) == PAR_ODD);
        par_odd    = (par_mode_e'(par_sel) == PAR_ODD);
        last_idx   = IW'(LEN_MIN - 1) + IW'(len_sel);
        start_seen = tick && !rxs;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_seen) state_nx = ST_START;
            end
            ST_START: begin
                if (vote_done && vote_val) state_nx = ST_IDLE;
                else if (bit_end)          state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && (idx_q == last_idx))
                    state_nx = par_on ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_end) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (vote_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        run = (state_q != ST_IDLE) || !rxs;
        clr = vote_done && (((state_q == ST_START) && vote_val) || (state_q == ST_STOP));
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q      <= '0;
            idx_q      <= '0;
            acc_q      <= 1'b0;
            pbit_q     <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_seen) begin
                        shf_q <= '0;
                        idx_q <= '0;
                        acc_q <= 1'b0;
                    end
                end
                ST_START: begin
                end
                ST_DATA: begin
                    if (vote_done) begin
                        shf_q[idx_q] <= vote_val;
                        acc_q        <= acc_q ^ vote_val;
                    end
                    if (bit_end) idx_q <= idx_q + IW'(1);
                end
                ST_PARITY: begin
                    if (vote_done) pbit_q <= vote_val;
                end
                ST_STOP: begin
                    if (vote_done) begin
                        rx_data    <= shf_q;
                        rx_frm_err <= !vote_val;
                        rx_par_err <= par_on && (acc_q ^ pbit_q ^ par_odd);
                        rx_valid   <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_vote_rx.sv
module serial_vote_rx #(
    parameter int OSR_NORM    = 16,
    parameter int OSR_FAST    = 8,
    parameter int DATA_MAX    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                fast_mode,
    input  logic [1:0]          data_len,
    input  logic [1:0]          par_mode,
    input  logic                rx_line,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_par_err,
    output logic                rx_frm_err
);
    logic rx_s;
    logic run;
    logic clr;
    logic bit_end;
    logic vote_done;
    logic vote_val;

    svr_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .d_out (rx_s)
    );

    svr_slot_vote #(
        .OSR_NORM (OSR_NORM),
        .OSR_FAST (OSR_FAST)
    ) u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .fast      (fast_mode),
        .run       (run),
        .clr       (clr),
        .smp       (rx_s),
        .bit_end   (bit_end),
        .vote_done (vote_done),
        .vote_val  (vote_val)
    );

    svr_frame_fsm #(
        .DATA_MAX (DATA_MAX)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .rxs        (rx_s),
        .vote_done  (vote_done),
        .vote_val   (vote_val),
        .bit_end    (bit_end),
        .len_sel    (data_len),
        .par_sel    (par_mode),
        .run        (run),
        .clr        (clr),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err)
    );

endmodule

// File: rtl/serial_vote_rx_chk.sv
module serial_vote_rx_chk #(
    parameter int DATA_MAX = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          data_len,
    input logic [1:0]          par_mode,
    input logic [DATA_MAX-1:0] rx_data,
    input logic                rx_valid,
    input logic                rx_par_err,
    input logic                rx_frm_err
);
    localparam int LEN_MIN = DATA_MAX - 3;

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_par_err) && $stable(rx_frm_err)));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (LEN_MIN + int'(data_len))) == '0));

    // R5
    no_parity_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && ((par_mode == 2'd0) || (par_mode == 2'd3))) |-> !rx_par_err);

endmodule

bind serial_vote_rx serial_vote_rx_chk #(.DATA_MAX(DATA_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_len   (data_len),
    .par_mode   (par_mode),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err)
);

// File: tb/tb_serial_vote_rx.sv
module tb_serial_vote_rx;

    logic       clk;
    logic       rst_n;
    logic       tick_en;
    logic       fast_mode;
    logic [1:0] data_len;
    logic [1:0] par_mode;
    logic       rx_line;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_par_err;
    logic       rx_frm_err;

    int checks = 0;
    int errors = 0;
    int sent   = 0;
    int got    = 0;
    bit done   = 0;

    logic [7:0] exp_d  [1024];
    logic       exp_pe [1024];
    logic       exp_fe [1024];
    string      exp_tag[1024];

    serial_vote_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .fast_mode  (fast_mode),
        .data_len   (data_len),
        .par_mode   (par_mode),
        .rx_line    (rx_line),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    // one enable every second clock
    initial begin
        tick_en = 1'b0;
        forever begin
            @(negedge clk);
            tick_en = ~tick_en;
        end
    end

    // result monitor: compares each frame against the expected list (R9 hold too)
    initial begin
        logic [7:0] ld;
        logic       lp;
        logic       lf;
        bit         hold_chk;
        ld = '0; lp = 1'b0; lf = 1'b0; hold_chk = 1'b0;
        forever begin
            @(negedge clk);
            if (hold_chk) begin
                checks++;
                if (rx_valid || rx_data !== ld || rx_par_err !== lp || rx_frm_err !== lf) begin
                    errors++;
                    $display("FAIL R9 hold: valid=%0b data=%02h pe=%0b fe=%0b expected valid=0 data=%02h pe=%0b fe=%0b",
                             rx_valid, rx_data, rx_par_err, rx_frm_err, ld, lp, lf);
                end
                hold_chk = 1'b0;
            end else if (rx_valid) begin
                checks++;
                if (got >= sent) begin
                    errors++;
                    $display("FAIL R3 unexpected frame: data=%02h expected no frame", rx_data);
                end else if (rx_data !== exp_d[got] || rx_par_err !== exp_pe[got] || rx_frm_err !== exp_fe[got]) begin
                    errors++;
                    $display("FAIL %s frame %0d: data=%02h pe=%0b fe=%0b expected data=%02h pe=%0b fe=%0b",
                             exp_tag[got], got, rx_data, rx_par_err, rx_frm_err,
                             exp_d[got], exp_pe[got], exp_fe[got]);
                end
                got++;
                ld = rx_data; lp = rx_par_err; lf = rx_frm_err;
                hold_chk = 1'b1;
            end
        end
    end

    task automatic wait_slots(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic send_bit(input logic v, input int n, input int sp1, input int sp2);
        for (int s = 1; s <= n; s++) begin
            rx_line = ((s == sp1) || (s == sp2)) ? ~v : v;
            wait_slots(1);
        end
    endtask

    // spike: 0 none, 1 one inverted centre sample in bit 0, 2 two inverted centre samples in bit 0
    task automatic send_frame(input logic [7:0] b, input int stop_n, input bit bad_par,
                              input bit bad_stop, input int spike, input string tag);
        int         n;
        int         c;
        int         nb;
        logic [7:0] dm;
        logic [7:0] rcv;
        logic       par_on;
        logic       odd;
        logic       pbit;
        n      = fast_mode ? 8 : 16;
        c      = n / 2 + 1;
        nb     = int'(data_len) + 5;
        dm     = b & 8'((1 << nb) - 1);
        par_on = (par_mode == 2'd1) || (par_mode == 2'd2);
        odd    = (par_mode == 2'd2);
        pbit   = (^dm) ^ odd ^ bad_par;
        rcv    = dm ^ ((spike == 2) ? 8'h01 : 8'h00);
        exp_d[sent]   = rcv;
        exp_pe[sent]  = par_on && ((^rcv) ^ pbit ^ odd);
        exp_fe[sent]  = bad_stop;
        exp_tag[sent] = tag;
        sent++;
        send_bit(1'b0, n, 0, 0);
        for (int i = 0; i < nb; i++)
            send_bit(dm[i], n, (i == 0 && spike >= 1) ? c : 0, (i == 0 && spike == 2) ? c + 1 : 0);
        if (par_on) send_bit(pbit, n, 0, 0);
        send_bit(~bad_stop, stop_n, 0, 0);
        if (bad_stop) send_bit(1'b1, 2 * n, 0, 0);
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while (got < sent && t < 4000) begin
            @(negedge clk);
            t++;
        end
        wait_slots(40);
        checks++;
        if (got != sent) begin
            errors++;
            $display("FAIL %s frame count: got=%0d expected=%0d", tag, got, sent);
        end
    endtask

    task automatic glitch(input string tag);
        rx_line = 1'b0;
        wait_slots(fast_mode ? 3 : 7);
        rx_line = 1'b1;
        wait_slots(fast_mode ? 24 : 48);
        drain(tag);
    endtask

    task automatic directed_set;
        int n;
        n = fast_mode ? 8 : 16;
        data_len = 2'd3;
        par_mode = 2'd1;
        wait_slots(4);
        send_frame(8'h5A, n, 1'b0, 1'b0, 1, "R2 single spike");
        send_frame(8'hA5, n, 1'b0, 1'b0, 1, "R2 single spike");
        send_frame(8'h5A, n, 1'b0, 1'b0, 2, "R2 double spike");
        send_frame(8'h3C, n, 1'b1, 1'b0, 0, "R5 bad parity");
        drain("R5");
        send_frame(8'hC3, n, 1'b0, 1'b1, 0, "R6 stop low");
        drain("R6");
        glitch("R3 glitch");
        send_frame(8'h96, 2 * n, 1'b0, 1'b0, 0, "R7 two stop bits");
        send_frame(8'h69, 3 * n, 1'b0, 1'b0, 0, "R7 long idle");
        send_frame(8'hE7, fast_mode ? 7 : 11, 1'b0, 1'b0, 0, "R8 early start");
        send_frame(8'h18, n, 1'b0, 1'b0, 0, "R8 after early start");
        drain("R7");
    endtask

    initial begin
        logic [7:0] pats [6];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

        rst_n     = 1'b0;
        rx_line   = 1'b1;
        fast_mode = 1'b0;
        data_len  = 2'd3;
        par_mode  = 2'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rx_valid !== 1'b0 || rx_data !== 8'h00 || rx_par_err !== 1'b0 || rx_frm_err !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: valid=%0b data=%02h pe=%0b fe=%0b expected all 0",
                     rx_valid, rx_data, rx_par_err, rx_frm_err);
        end
        wait_slots(40);
        checks++;
        if (got != 0) begin
            errors++;
            $display("FAIL R3 idle line: got=%0d expected=0", got);
        end

        // R1 R4 R5 R7 R8: sweep of word length and parity mode in both speeds
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 4; l++) begin
                for (int p = 0; p < 4; p++) begin
                    int n;
                    fast_mode = m[0];
                    data_len  = l[1:0];
                    par_mode  = p[1:0];
                    n = fast_mode ? 8 : 16;
                    wait_slots(4);
                    for (int j = 0; j < 6; j++) begin
                        int st;
                        st = (j % 3 == 0) ? n : ((j % 3 == 1) ? (fast_mode ? 7 : 11) : 2 * n);
                        send_frame(pats[j], st, 1'b0, 1'b0, 0, "R1 R4 sweep");
                    end
                    drain("R1 R4");
                end
            end
        end

        fast_mode = 1'b0;
        directed_set();
        fast_mode = 1'b1;
        directed_set();

        // R8: every byte, fast mode, even parity, stop bits alternately cut short
        fast_mode = 1'b1;
        data_len  = 2'd3;
        par_mode  = 2'd1;
        wait_slots(4);
        for (int v = 0; v < 256; v++)
            send_frame(8'(v), (v % 2 == 1) ? 7 : 8, 1'b0, 1'b0, 0, "R8 byte sweep");
        drain("R8");

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule